// File: doc/BRIEF.md
# Clocked Serial Port with Buffered Block Transfer

This block is an 8-bit clocked serial port with three lines: a clock, a data output and a data input. It can drive the clock itself from an internal divider, or it can follow a clock supplied from outside. A transfer moves a programmed number of bits, from 1 to 256, between the serial lines and a 32-byte buffer inside the block. Each buffer byte is shifted out and is then replaced by the byte that was shifted in during the same eight clocks. A single-byte exchange is the same operation with a length of eight bits.

Software fills the buffer through a simple byte write port. It sets the length, the bit order and the clock source, and then pulses `start`. While `pause_req` is high, the engine halts at the next byte boundary and holds the line clock high. When `pause_req` drops, the engine continues with the next byte. The count of completed bytes is always visible. At the end of the transfer the clock rests high and a done flag is raised. Received data is then read back through the same buffer port.

Top module: `ssp_blk`

## Requirements
- R1: After reset, `sck_out` and `sdo` are 1, and `busy`, `held`, `done` and `byte_cnt` are 0.
- R2: In master mode, `sck_out` idles high. Each half period lasts `brg_div`+1 clock cycles. The first falling edge comes `brg_div`+1 cycles after the cycle in which `start` is accepted.
- R3: `sdo` changes only on the clock cycle in which `sck_out` falls. Input data is sampled on the cycle in which `sck_out` rises.
- R4: With `msb_first`=1, bit 7 of a full byte goes out first. With `msb_first`=0, bit 0 goes out first.
- R5: A transfer carries exactly `bit_count`+1 bits. On the rising edge that ends the last bit, `busy` falls, `done` rises and `sck_out` stays high. `done` stays set until the next start.
- R6: The received byte is written into the same buffer slot that supplied the transmitted byte, at slot index `byte_cnt`.
- R7: A final byte of n<8 bits sends bits n-1..0 of its slot, in the order that R4 selects. The n received bits are stored right-aligned, with the upper 8-n bits cleared.
- R8: If `pause_req` is high when a non-final byte completes, `held` goes to 1. While `held` is 1 there are no clock edges and `sck_out` stays high. One cycle after `pause_req` is low, `held` clears and the next byte proceeds.
- R9: `byte_cnt` resets to 0 on start and increases by exactly 1 as each byte, full or partial, completes.
- R10: With `slave_mode`=1, the engine shifts only on edges of `sck_in` after a two-stage synchronizer, and it samples `sdi` through the same delay. `brg_div` has no effect and `sck_out` stays high.
- R11: A `start` pulse while `busy` is 1 is ignored. The length and the byte count of the running transfer are unchanged.
- R12: If `pause_req` is high when the final byte completes, the transfer ends with `done`=1 and `held`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse that begins a transfer when idle |
| pause_req | input | 1 | Halt at the next byte boundary while high |
| msb_first | input | 1 | Bit order: 1 sends MSB first |
| slave_mode | input | 1 | 1 follows `sck_in`; 0 drives `sck_out` |
| brg_div | input | 8 | Half-period divider, minus one |
| bit_count | input | 8 | Transfer length in bits, minus one |
| sck_in | input | 1 | External serial clock |
| sdi | input | 1 | Serial data input |
| sck_out | output | 1 | Generated serial clock, idles high |
| sdo | output | 1 | Serial data output |
| busy | output | 1 | Transfer in progress |
| held | output | 1 | Halted at a byte boundary |
| done | output | 1 | Sticky completion flag |
| byte_cnt | output | 6 | Bytes completed in this transfer |
| cpu_we | input | 1 | Buffer write strobe |
| cpu_addr | input | 5 | Buffer byte address |
| cpu_wdata | input | 8 | Buffer write data |
| cpu_rdata | output | 8 | Buffer read data at `cpu_addr` |

## Verification
The key collision happens at the completion edge of the last byte. The end-of-transfer rule and the pause rule both apply on that edge. The bench provokes this by holding `pause_req` high through a whole transfer. It then judges that `done` is set, `held` stays clear and the clock rests high. A second test drives `pause_req` high during a longer transfer, so that the pause lands on an inner boundary. A further collision pulses `start` while a transfer is running, so it falls in the same window as shifting. There the behavioural model and the byte count must both show that the running transfer is untouched.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  typedef struct packed {
    logic fall;
    logic rise;
    logic din;
  } edge_ev_t;

  // Mask keeping the low n bits (n in 1..8).
  function automatic logic [7:0] low_mask(input logic [3:0] n);
    return 8'hFF >> (4'd8 - n);
  endfunction
endpackage

// File: rtl/ssp_baud.sv
module ssp_baud #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             sck,
  output logic             tick_fall,
  output logic             tick_rise
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             sck_q, sck_d;

  always_comb begin
    cnt_d     = cnt_q;
    sck_d     = sck_q;
    tick_fall = 1'b0;
    tick_rise = 1'b0;
    if (!run) begin
      cnt_d = '0;
      sck_d = 1'b1;
    end else if (cnt_q == div) begin
      cnt_d     = '0;
      sck_d     = ~sck_q;
      tick_fall = sck_q;
      tick_rise = ~sck_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sck_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      sck_q <= sck_d;
    end
  end

  assign sck = sck_q;
endmodule

// File: rtl/ssp_sync.sv
module ssp_sync
  import ssp_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     sck_in,
  input  logic     sdi,
  output edge_ev_t ev
);
  logic [STAGES:0]   ck_q;
  logic [STAGES-1:0] dq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_q <= '1;
      dq_q <= '1;
    end else begin
      ck_q <= {ck_q[STAGES-1:0], sck_in};
      dq_q <= {dq_q[STAGES-2:0], sdi};
    end
  end

  always_comb begin
    ev.fall = ck_q[STAGES] & ~ck_q[STAGES-1];
    ev.rise = ~ck_q[STAGES] & ck_q[STAGES-1];
    ev.din  = dq_q[STAGES-1];
  end
endmodule

// File: rtl/ssp_buf.sv
module ssp_buf #(
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          eng_we,
  input  logic [AW-1:0] eng_addr,
  input  logic [7:0]    eng_wdata,
  output logic [7:0]    eng_rdata,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [7:0]    cpu_wdata,
  output logic [7:0]    cpu_rdata
);
  logic [7:0] mem [DEPTH];
  logic       cpu_ok;

  // Engine write wins a same-slot collision.
  assign cpu_ok = cpu_we & ~(eng_we & (eng_addr == cpu_addr));

  always_ff @(posedge clk) begin
    if (cpu_ok) mem[cpu_addr] <= cpu_wdata;
    if (eng_we) mem[eng_addr] <= eng_wdata;
  end

  assign eng_rdata = mem[eng_addr];
  assign cpu_rdata = mem[cpu_addr];
endmodule

// File: rtl/ssp_blk.sv
module ssp_blk
  import ssp_pkg::*;
#(
  parameter int BUF_BYTES   = 32,
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2,
  localparam int AW         = $clog2(BUF_BYTES),
  localparam int LEN_W      = AW + 3,
  localparam int CNT_W      = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             pause_req,
  input  logic             msb_first,
  input  logic             slave_mode,
  input  logic [DIV_W-1:0] brg_div,
  input  logic [LEN_W-1:0] bit_count,
  input  logic             sck_in,
  input  logic             sdi,
  output logic             sck_out,
  output logic             sdo,
  output logic             busy,
  output logic             held,
  output logic             done,
  output logic [CNT_W-1:0] byte_cnt,
  input  logic             cpu_we,
  input  logic [AW-1:0]    cpu_addr,
  input  logic [7:0]       cpu_wdata,
  output logic [7:0]       cpu_rdata
);
  logic             busy_q, busy_d, held_q, held_d, done_q, done_d, sdo_q, sdo_d;
  logic [CNT_W-1:0] bcnt_q, bcnt_d;
  logic [2:0]       kbit_q, kbit_d;
  logic [LEN_W-1:0] blen_q, blen_d;
  logic [7:0]       rx_q, rx_d;

  logic             run, m_fall, m_rise, ev_fall, ev_rise, din;
  edge_ev_t         s_ev;
  logic [AW-1:0]    slot;
  logic             last_byte, last_bit, eng_we;
  logic [3:0]       nbits;
  logic [2:0]       tx_idx;
  logic [7:0]       tx_byte, rx_shift, rx_store;

  assign run = busy_q & ~held_q;

  ssp_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .run(run & ~slave_mode), .div(brg_div),
    .sck(sck_out), .tick_fall(m_fall), .tick_rise(m_rise)
  );

  ssp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sck_in(sck_in), .sdi(sdi), .ev(s_ev)
  );

  ssp_buf #(.DEPTH(BUF_BYTES)) u_buf (
    .clk(clk), .eng_we(eng_we), .eng_addr(slot), .eng_wdata(rx_store),
    .eng_rdata(tx_byte), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata)
  );

  // Edge source selection
  assign ev_fall = slave_mode ? (run & s_ev.fall) : m_fall;
  assign ev_rise = slave_mode ? (run & s_ev.rise) : m_rise;
  assign din     = slave_mode ? s_ev.din : sdi;

  // Byte geometry: the last byte may be partial
  assign slot      = bcnt_q[AW-1:0];
  assign last_byte = (slot == blen_q[LEN_W-1:3]);
  assign nbits     = last_byte ? ({1'b0, blen_q[2:0]} + 4'd1) : 4'd8;
  assign last_bit  = ({1'b0, kbit_q} == (nbits - 4'd1));
  assign tx_idx    = msb_first ? 3'(nbits - 4'd1 - {1'b0, kbit_q}) : kbit_q;
  assign rx_shift  = msb_first ? {rx_q[6:0], din} : {din, rx_q[7:1]};
  assign rx_store  = msb_first ? (rx_shift & low_mask(nbits))
                               : (rx_shift >> (4'd8 - nbits));

  always_comb begin
    busy_d = busy_q;
    held_d = held_q;
    done_d = done_q;
    sdo_d  = sdo_q;
    bcnt_d = bcnt_q;
    kbit_d = kbit_q;
    blen_d = blen_q;
    rx_d   = rx_q;
    eng_we = 1'b0;
    if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1;
        held_d = 1'b0;
        done_d = 1'b0;
        bcnt_d = '0;
        kbit_d = '0;
        blen_d = bit_count;
      end
    end else if (held_q) begin
      if (!pause_req) held_d = 1'b0;
    end else if (ev_fall) begin
      sdo_d = tx_byte[tx_idx];
    end else if (ev_rise) begin
      rx_d   = rx_shift;
      kbit_d = kbit_q + 3'd1;
      if (last_bit) begin
        eng_we = 1'b1;
        kbit_d = '0;
        bcnt_d = bcnt_q + 1'b1;
        if (last_byte) begin
          busy_d = 1'b0;
          done_d = 1'b1;
        end else if (pause_req) begin
          held_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      held_q <= 1'b0;
      done_q <= 1'b0;
      sdo_q  <= 1'b1;
      bcnt_q <= '0;
      kbit_q <= '0;
      blen_q <= '0;
      rx_q   <= '0;
    end else begin
      busy_q <= busy_d;
      held_q <= held_d;
      done_q <= done_d;
      sdo_q  <= sdo_d;
      bcnt_q <= bcnt_d;
      kbit_q <= kbit_d;
      blen_q <= blen_d;
      rx_q   <= rx_d;
    end
  end

  assign busy     = busy_q;
  assign held     = held_q;
  assign done     = done_q;
  assign sdo      = sdo_q;
  assign byte_cnt = bcnt_q;
endmodule

// File: rtl/ssp_blk_chk.sv
module ssp_blk_chk #(
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sck_out,
  input logic             sdo,
  input logic             busy,
  input logic             held,
  input logic             done,
  input logic             slave_mode,
  input logic [CNT_W-1:0] byte_cnt
);
  a_r2_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sck_out);

  a_r3_sdo_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (!slave_mode && !$stable(sdo)) |-> $fell(sck_out));

  a_r5_done_rests_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (sck_out && !busy));

  a_r8_held_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    held |-> (sck_out && busy));

  a_r9_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && (byte_cnt != $past(byte_cnt))) |->
      ((byte_cnt - $past(byte_cnt)) == CNT_W'(1)));

  a_r10_slave_no_clock: assert property (@(posedge clk) disable iff (!rst_n)
    slave_mode |-> sck_out);
endmodule

bind ssp_blk ssp_blk_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sck_out(sck_out), .sdo(sdo), .busy(busy),
  .held(held), .done(done), .slave_mode(slave_mode), .byte_cnt(byte_cnt)
);

// File: tb/ssp_blk_bench.sv
module ssp_blk_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, pause_req = 1'b0, msb_first = 1'b0, slave_mode = 1'b0;
  logic [7:0] brg_div = 8'd0, bit_count = 8'd0;
  logic       sck_in = 1'b1, sdi = 1'b1;
  logic       sck_out, sdo, busy, held, done;
  logic [5:0] byte_cnt;
  logic       cpu_we = 1'b0;
  logic [4:0] cpu_addr = 5'd0;
  logic [7:0] cpu_wdata = 8'd0, cpu_rdata;

  int errors = 0, checks = 0, cyc = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  ssp_blk u_ssp_blk (
    .clk(clk), .rst_n(rst_n), .start(start), .pause_req(pause_req),
    .msb_first(msb_first), .slave_mode(slave_mode), .brg_div(brg_div),
    .bit_count(bit_count), .sck_in(sck_in), .sdi(sdi), .sck_out(sck_out),
    .sdo(sdo), .busy(busy), .held(held), .done(done), .byte_cnt(byte_cnt),
    .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata)
  );

  // Reference model state
  logic [7:0] m_mem [32];
  bit   m_busy = 0, m_held = 0, m_done = 0, m_sck = 1, m_sdo = 1;
  int   m_cnt = 0, m_ph = 0, m_k = 0, m_len = 1, n = 8, by = 0, ewa = 0;
  logic [7:0] rxv = 0, evv = 0;
  bit   run, fe, re, smp, lastb, ew;
  bit   q1 = 1, q2 = 1, q3 = 1, d1 = 1, d2 = 1;
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Pseudo-random serial input, changed away from the active edge
  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    sdi  <= lfsr[0];
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_held = 0; m_done = 0; m_sck = 1; m_sdo = 1;
      m_cnt = 0; m_ph = 0; m_k = 0; m_len = 1; rxv = 0;
      q1 = 1; q2 = 1; q3 = 1; d1 = 1; d2 = 1;
    end else begin
      run = m_busy && !m_held; fe = 0; re = 0; ew = 0;
      if (run && !slave_mode) begin
        if (m_ph == brg_div) begin
          m_ph = 0; fe = m_sck; re = !m_sck; m_sck = !m_sck;
        end else m_ph = m_ph + 1;
      end else begin
        m_ph = 0; m_sck = 1;
      end
      if (run && slave_mode) begin
        fe = q3 && !q2; re = !q3 && q2;
      end
      smp = slave_mode ? d2 : sdi;
      by = m_cnt;
      lastb = (by == (m_len - 1) / 8);
      n = lastb ? ((m_len - 1) % 8) + 1 : 8;
      if (!m_busy) begin
        if (start) begin
          m_busy = 1; m_held = 0; m_done = 0; m_cnt = 0; m_k = 0;
          m_len = bit_count + 1; rxv = 0;
        end
      end else if (m_held) begin
        if (!pause_req) m_held = 0;
      end else if (fe) begin
        m_sdo = msb_first ? m_mem[by][n-1-m_k] : m_mem[by][m_k];
      end else if (re) begin
        if (msb_first) rxv[n-1-m_k] = smp; else rxv[m_k] = smp;
        if (m_k == n - 1) begin
          ew = 1; evv = rxv; ewa = by; rxv = 0; m_k = 0; m_cnt++;
          if (lastb) begin m_busy = 0; m_done = 1; end
          else if (pause_req) m_held = 1;
        end else m_k++;
      end
      if (cpu_we) m_mem[cpu_addr] = cpu_wdata;
      if (ew) m_mem[ewa] = evv;
      q3 = q2; q2 = q1; q1 = sck_in; d2 = d1; d1 = sdi;
    end
  end

  // Per-cycle comparison against the model, plus watchdog
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R2 sck_out", sck_out, m_sck);
      check("R3/R4 sdo", sdo, m_sdo);
      check("R5 busy", busy, m_busy);
      check("R5 done", done, m_done);
      check("R9 byte_cnt", byte_cnt, m_cnt);
      check("R8 held", held, m_held);
      cyc++;
      if (cyc > 100000) begin
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected=<100000", cyc);
        finish_run();
      end
    end
  end

  task automatic cpu_write(input int a, input logic [7:0] d);
    @(negedge clk); cpu_we = 1'b1; cpu_addr = 5'(a); cpu_wdata = d;
    @(negedge clk); cpu_we = 1'b0;
  endtask

  task automatic kick(input bit msb, input bit slv, input int div, input int len);
    @(negedge clk);
    msb_first = msb; slave_mode = slv; brg_div = 8'(div); bit_count = 8'(len - 1);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (m_busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check_buffer(input string req);
    for (int i = 0; i < 32; i++) begin
      @(negedge clk); cpu_addr = 5'(i); #1;
      check(req, cpu_rdata, m_mem[i]);
    end
  endtask

  task automatic slave_clocks(input int edges);
    for (int i = 0; i < edges; i++) begin
      sck_in = 1'b0; repeat (4) @(negedge clk);
      sck_in = 1'b1; repeat (4) @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state
    check("R1 sck_out", sck_out, 1); check("R1 sdo", sdo, 1);
    check("R1 busy", busy, 0); check("R1 done", done, 0);
    check("R1 byte_cnt", byte_cnt, 0); check("R1 held", held, 0);

    for (int i = 0; i < 32; i++) cpu_write(i, 8'(i * 37 + 5));
    check_buffer("R6 preload");

    // LSB first, fastest clock, two bytes; a start pulse mid-run (R11)
    kick(0, 0, 0, 16);
    repeat (7) @(negedge clk);
    bit_count = 8'd200; start = 1'b1;
    @(negedge clk); start = 1'b0;
    wait_idle();
    check("R11 length kept", byte_cnt, 2);
    check("R5 done after 16", done, 1);
    check_buffer("R6 in place lsb");

    // MSB first, slower clock, 13 bits -> partial byte of 5 (R4, R7)
    kick(1, 0, 2, 13);
    wait_idle();
    cpu_addr = 5'd1; #1;
    check("R7 upper cleared msb", {24'd0, cpu_rdata & 8'hE0}, 0);
    check_buffer("R7 partial msb");

    // Single bit, LSB first (R7)
    kick(0, 0, 1, 1);
    wait_idle();
    check("R9 one byte", byte_cnt, 1);
    cpu_addr = 5'd0; #1;
    check("R7 upper cleared lsb", {24'd0, cpu_rdata & 8'hFE}, 0);

    // Pause at an inner byte boundary (R8)
    kick(0, 0, 1, 24);
    pause_req = 1'b1;
    while (!m_held) @(negedge clk);
    check("R8 held at boundary", held, 1);
    repeat (20) @(negedge clk);
    check("R8 count frozen", byte_cnt, 1);
    pause_req = 1'b0;
    wait_idle();
    check("R8 resumed to end", byte_cnt, 3);
    check_buffer("R6 after pause");

    // Pause request colliding with the final boundary (R12)
    pause_req = 1'b1;
    kick(1, 0, 0, 8);
    wait_idle();
    check("R12 done wins", done, 1);
    check("R12 not held", held, 0);
    pause_req = 1'b0;

    // Full 256-bit transfer (R5)
    kick(1, 0, 0, 256);
    wait_idle();
    check("R5 full length bytes", byte_cnt, 32);
    check_buffer("R6 full length");

    // Slave mode on external clock, divider value irrelevant (R10)
    kick(0, 1, 255, 12);
    repeat (3) @(negedge clk);
    slave_clocks(12);
    wait_idle();
    check("R10 slave bytes", byte_cnt, 2);
    check("R10 slave done", done, 1);
    check_buffer("R10 slave buffer");
    slave_mode = 1'b0;

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule